// File: doc/BRIEF.md
# Centred-Bitmap VGA Display Generator

This block produces a 640x480, 60 Hz VGA picture from a 50 MHz clock. A pixel strobe on every second clock gives a 25 MHz pixel rate. A horizontal and a vertical scan counter step on that strobe and generate active-low sync pulses. The picture has three 1-bit colour outputs.

Outside a fixed window, every visible pixel takes the background colour set by three level inputs, one per colour channel. A 256x96 window sits in the middle of the screen. Inside it, the colour comes from a bitmap store with a one-pixel registered read. Sync, blanking and the window flag are delayed by the same pixel, so picture and sync stay aligned.

All geometry is set by parameters. The window origin is derived from them, so a smaller raster can be built for fast checking.

Top module: `vgw_display`

## Requirements
- R1: With default parameters a line is 800 pixel periods and a frame is 525 lines. The horizontal counter steps by one per pixel strobe, wraps from 799 to 0, and the line counter steps on that wrap.
- R2: The pixel strobe is low on the first clock edge after reset release and then toggles on every edge, so one pixel period lasts two clocks.
- R3: `hsync_n_o` is low exactly while the displayed pixel column is 656 to 751 inclusive, and high otherwise.
- R4: `vsync_n_o` is low exactly while the displayed line is 490 or 491, and high otherwise.
- R5: A visible pixel outside the window shows red = `bg_red_i`, green = `bg_grn_i`, blue = `bg_blu_i`, following the inputs combinationally.
- R6: Inside the window (columns 192 to 447, rows 192 to 287), the colour is the bitmap word at local column c and local row r. The word is c[2:0] XOR r[2:0]; bit 2 drives red, bit 1 green and bit 0 blue. The background inputs have no effect there.
- R7: All three colour outputs are 0 for any column of 640 or above or any line of 480 or above.
- R8: While `rst_i` is high (asynchronous), both syncs are high, all colours are 0 and the scan restarts at column 0, line 0.
- R9: After the k-th pixel strobe since reset, every output shows scan position k-1 (one pixel of latency), and outputs change only on strobe edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| bg_red_i | input | 1 | Background red enable |
| bg_grn_i | input | 1 | Background green enable |
| bg_blu_i | input | 1 | Background blue enable |
| red_o | output | 1 | Red pixel bit |
| grn_o | output | 1 | Green pixel bit |
| blu_o | output | 1 | Blue pixel bit |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |

## Verification
The hardest conditions to reach from the ports are the window edges, the vertical sync band and the frame wrap. At full size they lie hundreds of thousands of clocks after reset. The bench therefore runs a second instance, built with a 64x48 raster and a 16x8 window, through two whole frames, while the default-size instance is checked over its first lines for real horizontal timing and background colour. A reset is also asserted in the middle of a frame, and the bench shows that the scan restarts from the origin.

// File: rtl/vgw_pkg.sv
package vgw_pkg;

   typedef struct packed {
      logic r;
      logic g;
      logic b;
   } rgb_t;

   // Bitmap image content: a generated test pattern, one bit per channel.
   function automatic rgb_t bitmap_word(input logic [2:0] col, input logic [2:0] row);
      logic [2:0] w;
      w = col ^ row;
      return rgb_t'(w);
   endfunction

endpackage

// File: rtl/vgw_pixel_strobe.sv
module vgw_pixel_strobe #(
   parameter int DIVIDE = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic pix_en_o
);
   localparam int CW = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;

   generate
      if (DIVIDE < 1) begin : g_bad
         $error("vgw_pixel_strobe: DIVIDE must be at least 1");
      end
      if (DIVIDE == 1) begin : g_every
         assign pix_en_o = 1'b1;
      end else begin : g_div
         logic [CW-1:0] phase;
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i)                         phase <= '0;
            else if (int'(phase) == DIVIDE-1)  phase <= '0;
            else                               phase <= phase + 1'b1;
         end
         assign pix_en_o = (int'(phase) == DIVIDE-1);
      end
   endgenerate
endmodule

// File: rtl/vgw_scan_counter.sv
module vgw_scan_counter #(
   parameter int VISIBLE = 640,
   parameter int FRONT   = 16,
   parameter int SYNC    = 96,
   parameter int BACK    = 48,
   localparam int TOTAL  = VISIBLE + FRONT + SYNC + BACK,
   localparam int CW     = $clog2(TOTAL)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          step_i,
   output logic [CW-1:0] count_o,
   output logic          last_o,
   output logic          active_o,
   output logic          sync_n_o
);
   localparam int SYNC_LO = VISIBLE + FRONT;
   localparam int SYNC_HI = VISIBLE + FRONT + SYNC;

   if (VISIBLE < 1 || SYNC < 1) begin : g_bad
      $error("vgw_scan_counter: VISIBLE and SYNC must be positive");
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)       count_o <= '0;
      else if (step_i) count_o <= last_o ? '0 : count_o + 1'b1;
   end

   assign last_o   = (int'(count_o) == TOTAL - 1);
   assign active_o = (int'(count_o) < VISIBLE);
   assign sync_n_o = !((int'(count_o) >= SYNC_LO) && (int'(count_o) < SYNC_HI));
endmodule

// File: rtl/vgw_bitmap_rom.sv
module vgw_bitmap_rom
   import vgw_pkg::*;
#(
   parameter int COL_W = 8,
   parameter int ROW_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [ROW_W-1:0] row_i,
   output rgb_t             word_o
);
   if (COL_W < 3 || ROW_W < 3) begin : g_bad
      $error("vgw_bitmap_rom: window needs at least 8 columns and 5 rows");
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)     word_o <= '0;
      else if (en_i) word_o <= bitmap_word(col_i[2:0], row_i[2:0]);
   end
endmodule

// File: rtl/vgw_display.sv
module vgw_display
   import vgw_pkg::*;
#(
   parameter int H_VISIBLE = 640,
   parameter int H_FRONT   = 16,
   parameter int H_SYNC    = 96,
   parameter int H_BACK    = 48,
   parameter int V_VISIBLE = 480,
   parameter int V_FRONT   = 10,
   parameter int V_SYNC    = 2,
   parameter int V_BACK    = 33,
   parameter int WIN_W     = 256,
   parameter int WIN_H     = 96,
   parameter int CLK_DIV   = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bg_red_i,
   input  logic bg_grn_i,
   input  logic bg_blu_i,
   output logic red_o,
   output logic grn_o,
   output logic blu_o,
   output logic hsync_n_o,
   output logic vsync_n_o
);
   localparam int H_TOTAL = H_VISIBLE + H_FRONT + H_SYNC + H_BACK;
   localparam int V_TOTAL = V_VISIBLE + V_FRONT + V_SYNC + V_BACK;
   localparam int HW      = $clog2(H_TOTAL);
   localparam int VW      = $clog2(V_TOTAL);
   localparam int COL_W   = $clog2(WIN_W);
   localparam int ROW_W   = $clog2(WIN_H);
   localparam int WIN_X   = (H_VISIBLE - WIN_W) / 2;
   localparam int WIN_Y   = (V_VISIBLE - WIN_H) / 2;

   if (WIN_W != (1 << COL_W)) begin : g_bad_w
      $error("vgw_display: WIN_W must be a power of two");
   end
   if (WIN_W > H_VISIBLE || WIN_H > V_VISIBLE) begin : g_bad_fit
      $error("vgw_display: window larger than visible area");
   end

   logic          pix_en;
   logic [HW-1:0] h_cnt;
   logic [VW-1:0] v_cnt;
   logic          h_last, v_last, h_act, v_act, h_sync_n, v_sync_n;

   vgw_pixel_strobe #(.DIVIDE(CLK_DIV)) u_strobe (
      .clk_i(clk_i), .rst_i(rst_i), .pix_en_o(pix_en));

   vgw_scan_counter #(.VISIBLE(H_VISIBLE), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK))
   u_hscan (
      .clk_i(clk_i), .rst_i(rst_i), .step_i(pix_en),
      .count_o(h_cnt), .last_o(h_last), .active_o(h_act), .sync_n_o(h_sync_n));

   vgw_scan_counter #(.VISIBLE(V_VISIBLE), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK))
   u_vscan (
      .clk_i(clk_i), .rst_i(rst_i), .step_i(pix_en && h_last),
      .count_o(v_cnt), .last_o(v_last), .active_o(v_act), .sync_n_o(v_sync_n));

   // Window decode and local bitmap coordinates
   logic             in_win;
   logic [COL_W-1:0] win_col;
   logic [ROW_W-1:0] win_row;

   assign in_win  = (int'(h_cnt) >= WIN_X) && (int'(h_cnt) < WIN_X + WIN_W) &&
                    (int'(v_cnt) >= WIN_Y) && (int'(v_cnt) < WIN_Y + WIN_H);
   assign win_col = COL_W'(int'(h_cnt) - WIN_X);
   assign win_row = ROW_W'(int'(v_cnt) - WIN_Y);

   rgb_t bmp_q;

   vgw_bitmap_rom #(.COL_W(COL_W), .ROW_W(ROW_W)) u_rom (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(pix_en),
      .col_i(win_col), .row_i(win_row), .word_o(bmp_q));

   // Stage matching the bitmap read latency
   logic vis_q, win_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         vis_q     <= 1'b0;
         win_q     <= 1'b0;
         hsync_n_o <= 1'b1;
         vsync_n_o <= 1'b1;
      end else if (pix_en) begin
         vis_q     <= h_act && v_act;
         win_q     <= in_win;
         hsync_n_o <= h_sync_n;
         vsync_n_o <= v_sync_n;
      end
   end

   rgb_t pix;
   always_comb begin
      if (!vis_q)     pix = '0;
      else if (win_q) pix = bmp_q;
      else            pix = '{r: bg_red_i, g: bg_grn_i, b: bg_blu_i};
   end

   assign red_o = pix.r;
   assign grn_o = pix.g;
   assign blu_o = pix.b;

   logic unused_last;
   assign unused_last = v_last;
endmodule

// File: rtl/vgw_display_chk.sv
module vgw_display_chk #(
   parameter int H_TOTAL = 800,
   localparam int HW     = $clog2(H_TOTAL)
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          pix_en,
   input logic [HW-1:0] h_cnt,
   input logic          red_o,
   input logic          grn_o,
   input logic          blu_o,
   input logic          hsync_n_o,
   input logic          vsync_n_o
);
   // R2: the column holds between strobes
   p_hold_between_strobes_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !pix_en |=> $stable(h_cnt));

   // R1: step by one per strobe
   p_column_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (pix_en && int'(h_cnt) != H_TOTAL - 1) |=> (h_cnt == $past(h_cnt) + 1'b1));

   // R1: wrap at end of line
   p_line_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (pix_en && int'(h_cnt) == H_TOTAL - 1) |=> (h_cnt == '0));

   // R7: colour dark during either sync pulse
   p_dark_in_sync_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!hsync_n_o || !vsync_n_o) |-> ({red_o, grn_o, blu_o} == 3'b000));

   // R9: sync outputs move only on strobe edges
   p_sync_on_strobe_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !pix_en |=> $stable({hsync_n_o, vsync_n_o}));
endmodule

bind vgw_display vgw_display_chk #(.H_TOTAL(H_TOTAL)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .pix_en(pix_en), .h_cnt(h_cnt),
   .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
   .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o));

// File: tb/test_vgw_display.sv
module test_vgw_display;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] sw = 3'b000;   // {red, green, blue}

   always #10 clk = ~clk;     // 50 MHz

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   longint edges;

   always @(posedge clk or posedge rst) begin
      if (rst) edges <= 0;
      else     edges <= edges + 1;
   end

   // Full-size instance
   logic f_r, f_g, f_b, f_hs, f_vs;
   vgw_display i_vgw_display (
      .clk_i(clk), .rst_i(rst), .bg_red_i(sw[2]), .bg_grn_i(sw[1]), .bg_blu_i(sw[0]),
      .red_o(f_r), .grn_o(f_g), .blu_o(f_b), .hsync_n_o(f_hs), .vsync_n_o(f_vs));

   // Reduced raster: 64x48 visible, 16x8 window at (24,20)
   logic s_r, s_g, s_b, s_hs, s_vs;
   vgw_display #(.H_VISIBLE(64), .H_FRONT(4), .H_SYNC(8), .H_BACK(4),
                 .V_VISIBLE(48), .V_FRONT(2), .V_SYNC(2), .V_BACK(4),
                 .WIN_W(16), .WIN_H(8)) i_vgw_small (
      .clk_i(clk), .rst_i(rst), .bg_red_i(sw[2]), .bg_grn_i(sw[1]), .bg_blu_i(sw[0]),
      .red_o(s_r), .grn_o(s_g), .blu_o(s_b), .hsync_n_o(s_hs), .vsync_n_o(s_vs));

   // Reference model from the requirements: expected {r,g,b,hs,vs} and region tag
   task automatic model(input int ha, hf, hsy, hb, va, vf, vsy, vb, ww, wh,
                        input longint k, input logic [2:0] bg,
                        output logic [4:0] e, output string ctag);
      longint pos;
      int ht, vt, h, v, wx, wy, c, r;
      logic hs, vs, vis, win;
      logic [2:0] col;
      if (k == 0) begin          // R8 idle before first strobe
         e = 5'b000_11; ctag = "R8";
         return;
      end
      ht = ha + hf + hsy + hb;
      vt = va + vf + vsy + vb;
      pos = k - 1;               // R9 one pixel of latency
      h = int'(pos % ht);
      v = int'((pos / ht) % vt); // R1 wrap of line and frame
      hs = !(h >= ha + hf && h < ha + hf + hsy);   // R3
      vs = !(v >= va + vf && v < va + vf + vsy);   // R4
      vis = (h < ha) && (v < va);
      wx = (ha - ww) / 2; wy = (va - wh) / 2;
      win = (h >= wx) && (h < wx + ww) && (v >= wy) && (v < wy + wh);
      c = h - wx; r = v - wy;
      if (!vis) begin col = 3'b000; ctag = "R7"; end
      else if (win) begin col = 3'(c) ^ 3'(r); ctag = "R6"; end
      else begin col = bg; ctag = "R5"; end
      e = {col, hs, vs};
   endtask

   task automatic compare_one(input string inst, input logic [4:0] act, input logic [4:0] exp_v,
                              input string ctag);
      vectors++;
      if (act[4:2] !== exp_v[4:2]) begin
         errors++;
         $display("FAIL %s %s colour: got %b expected %b (edges %0d)", ctag, inst, act[4:2], exp_v[4:2], edges);
      end
      if (act[1] !== exp_v[1]) begin
         errors++;
         $display("FAIL R3 %s hsync: got %b expected %b (edges %0d)", inst, act[1], exp_v[1], edges);
      end
      if (act[0] !== exp_v[0]) begin
         errors++;
         $display("FAIL R4 %s vsync: got %b expected %b (edges %0d)", inst, act[0], exp_v[0], edges);
      end
   endtask

   // One check of both instances, sampled 1 ns after the falling edge.
   // R1 and R2 (line length and strobe rate) appear as the position model.
   task automatic check_now();
      logic [4:0] e;
      string t;
      longint k;
      k = rst ? 0 : edges / 2;
      model(640, 16, 96, 48, 480, 10, 2, 33, 256, 96, k, sw, e, t);
      compare_one("full", {f_r, f_g, f_b, f_hs, f_vs}, e, t);
      model(64, 4, 8, 4, 48, 2, 2, 4, 16, 8, k, sw, e, t);
      compare_one("small", {s_r, s_g, s_b, s_hs, s_vs}, e, t);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
         check_now();
      end
   endtask

   // Scenario: reset idle state (R8)
   task automatic t_reset_idle();
      rst = 1'b1;
      sw = 3'b111;
      repeat (3) begin
         @(negedge clk); #1;
         check_now();
      end
      @(negedge clk);
      rst = 1'b0;
      #1;
      check_now();
   endtask

   // Scenario: background colour patterns across the first visible run (R5, R2)
   task automatic t_background();
      logic [2:0] pats [4] = '{3'b100, 3'b010, 3'b001, 3'b101};
      foreach (pats[i]) begin
         sw = pats[i];
         run(40);
      end
   endtask

   // Scenario: rest of several full-size lines, horizontal sync and blanking (R3, R7)
   task automatic t_hsync_blank();
      sw = 3'b111;
      run(3 * 1600);
   endtask

   // Scenario: two frames of the small raster, window, vertical sync, wrap (R6, R4, R1)
   task automatic t_window_frames();
      sw = 3'b011;
      run(2 * 80 * 56 * 2);
      sw = 3'b000;
      run(80 * 56 * 2);
   endtask

   // Scenario: reset in the middle of a frame restarts the scan (R8, R9)
   task automatic t_mid_reset();
      sw = 3'b110;
      @(negedge clk);
      rst = 1'b1;
      #1;
      check_now();
      run(2);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check_now();
      run(80 * 56 * 2);
   endtask

   initial begin
      t_reset_idle();
      t_background();
      t_hsync_blank();
      t_window_frames();
      t_mid_reset();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule